// File: doc/BRIEF.md
# Dual-Bank Indexed Register Port

This block sits on a 16-bit parallel microprocessor bus as a slave and gives the processor access to two independent register banks: a host-side bank and a device-side bank. No register is mapped directly. The processor first writes a register index to a bank's command port. It then moves the value through that bank's data port in one data phase for a 16-bit register, or in two data phases for a 32-bit register. Address line `addr[1]` picks the bank and `addr[0]` picks between its data port and its command port.

The strobes `rd_n` and `wr_n` are sampled on `clk`. A transfer happens once per strobe, in the cycle where the strobe is first seen low after it was high. Chip select is judged in that same cycle. Each bank runs its own phase machine with the states IDLE (no open command), LO (index latched, first data phase pending) and HI (32-bit register, second data phase pending). Its transitions are:
- CMD: a command write moves the bank from any state to LO.
- NARROW: a data phase in LO on a 16-bit or undefined index moves it to IDLE.
- WIDE: a data phase in LO on a 32-bit index moves it to HI.
- CLOSE: a data phase in HI moves it to IDLE.
- STAY: a data phase in IDLE leaves it in IDLE.

Each bank holds four 16-bit registers at indices 0x00 to 0x03 and two 32-bit registers at indices 0x10 and 0x11. Both banks use the same layout.

Top module: `dual_bank_regport`

## Requirements
- R1: After reset every register in both banks reads zero, both banks are in IDLE and `dout` is zero.
- R2: A strobe seen while `cs_n` is high has no effect: no register changes, no phase advances and `dout` holds its value.
- R3: `addr[1]`=0 reaches the host bank and `addr[1]`=1 reaches the device bank. A write to one bank never changes the other bank's registers.
- R4: With `addr[0]`=1, a write latches `din[7:0]` as the bank's index. A read of a command port returns zero and does not disturb the bank's open sequence.
- R5: For a 16-bit index (0x00 to 0x03), one data phase with `addr[0]`=0 writes `din` to the register or reads the register onto `dout`.
- R6: For a 32-bit index (0x10, 0x11), the first data phase carries bits 15:0 and the second carries bits 31:16. The register changes only when the second half is written.
- R7: Once the data phases the index needs are complete, the bank is IDLE. A further data write is ignored and a further data read returns zero.
- R8: A data phase with no command since reset is ignored on write and returns zero on read.
- R9: A data write to an undefined index is dropped, and a data read of an undefined index returns zero.
- R10: Each bank keeps its own index and phase, so accesses to the two banks may be interleaved freely.
- R11: A command write in the middle of a 32-bit sequence discards the pending half and restarts at the first data phase.
- R12: A strobe held low for several cycles causes exactly one transfer.
- R13: Read data appears on `dout` at the clock edge where the read strobe is first sampled low, and stays there until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all strobes and address lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Bit 1 selects the bank (0 host, 1 device); bit 0 selects the port (0 data, 1 command) |
| din | input | 16 | Write data, or the index in bits 7:0 for a command write |
| dout | output | 16 | Read data from the last read transfer |

## Verification
Four behaviours are checked by the assertions on every cycle:
- `dout` holds steady whenever chip select or the read strobe is inactive.
- Every command write leaves its bank in LO.
- A data phase in HI always closes the sequence to IDLE.
- An IDLE bank stays IDLE until a command arrives, and a register holds its value in every cycle that does not write it.

The remaining properties depend on multi-access sequences, so only the bench's scenarios can show them: which half of a 32-bit value travels in which phase, that the commit is deferred until the second half, that one bank stays unaffected while the other is in mid-sequence, and that a long strobe counts once.

// File: rtl/regport_pkg.sv
package regport_pkg;

    // Phase of one bank's command/data sequence.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // no open command
        PH_LO   = 2'd1,  // index latched, first data phase pending
        PH_HI   = 2'd2   // 32-bit register, upper half pending
    } phase_e;

    localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/regport_regfile.sv
module regport_regfile #(
    parameter int unsigned DW     = 16,
    parameter int unsigned IW     = 8,
    parameter int unsigned N16    = 4,
    parameter int unsigned N32    = 2,
    parameter int unsigned BASE32 = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [2*DW-1:0] wr_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [2*DW-1:0] rd_word,
    output logic            rd_known,
    output logic            rd_wide
);

    localparam int unsigned WW = 2 * DW;

    logic [DW-1:0] narrow_q [N16];
    logic [WW-1:0] wide_q   [N32];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N16; i++) narrow_q[i] <= '0;
            for (int j = 0; j < N32; j++) wide_q[j]   <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N16; i++)
                if (wr_idx == IW'(i)) narrow_q[i] <= wr_data[DW-1:0];
            for (int j = 0; j < N32; j++)
                if (wr_idx == IW'(BASE32 + j)) wide_q[j] <= wr_data;
        end
    end

    always_comb begin
        rd_word  = '0;
        rd_known = 1'b0;
        rd_wide  = 1'b0;
        for (int i = 0; i < N16; i++)
            if (rd_idx == IW'(i)) begin
                rd_word  = {{DW{1'b0}}, narrow_q[i]};
                rd_known = 1'b1;
            end
        for (int j = 0; j < N32; j++)
            if (rd_idx == IW'(BASE32 + j)) begin
                rd_word  = wide_q[j];
                rd_known = 1'b1;
                rd_wide  = 1'b1;
            end
    end

    // A register only moves when its own index is written.
    for (genvar g = 0; g < N16; g++) begin : g_chk16
        assert_hold16_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IW'(g)) |=> $stable(narrow_q[g]));
    end
    for (genvar h = 0; h < N32; h++) begin : g_chk32
        assert_hold32_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IW'(BASE32 + h)) |=> $stable(wide_q[h]));
    end

endmodule

// File: rtl/regport_bank.sv
module regport_bank
    import regport_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned IW     = 8,
    parameter int unsigned N16    = 4,
    parameter int unsigned N32    = 2,
    parameter int unsigned BASE32 = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic          dat_wr,
    input  logic          dat_rd,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rd_half
);

    phase_e          st_q, st_d;
    logic [IW-1:0]   idx_q;
    logic [DW-1:0]   lo_q;
    logic [2*DW-1:0] rf_word;
    logic            rf_known, rf_wide;
    logic            rf_we;
    logic [2*DW-1:0] rf_data;
    logic            dat_any;

    assign dat_any = dat_wr | dat_rd;

    regport_regfile #(
        .DW(DW), .IW(IW), .N16(N16), .N32(N32), .BASE32(BASE32)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_we),
        .wr_idx  (idx_q),
        .wr_data (rf_data),
        .rd_idx  (idx_q),
        .rd_word (rf_word),
        .rd_known(rf_known),
        .rd_wide (rf_wide)
    );

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        if (cmd_wr) begin
            st_d = PH_LO;                                     // CMD
        end else if (dat_any) begin
            unique case (st_q)
                PH_IDLE: st_d = PH_IDLE;                      // STAY
                PH_LO:   st_d = (rf_known && rf_wide) ? PH_HI // WIDE
                                                      : PH_IDLE; // NARROW
                PH_HI:   st_d = PH_IDLE;                      // CLOSE
                default: st_d = PH_IDLE;
            endcase
        end
    end

    // State, index and low-half staging registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PH_IDLE;
            idx_q <= '0;
            lo_q  <= '0;
        end else begin
            st_q <= st_d;
            if (cmd_wr) idx_q <= din[IW-1:0];
            if (dat_wr && st_q == PH_LO) lo_q <= din;
        end
    end

    // Outputs: register-file write and read half selection.
    always_comb begin
        rf_we   = 1'b0;
        rf_data = {{DW{1'b0}}, din};
        rd_half = '0;
        unique case (st_q)
            PH_IDLE: ;
            PH_LO: begin
                rf_we   = dat_wr && !cmd_wr && rf_known && !rf_wide;
                rd_half = rf_known ? rf_word[DW-1:0] : '0;
            end
            PH_HI: begin
                rf_we   = dat_wr && !cmd_wr;
                rf_data = {din, lo_q};
                rd_half = rf_word[2*DW-1:DW];
            end
            default: ;
        endcase
    end

    assert_cmd_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> st_q == PH_LO);

    assert_hi_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_HI && dat_any && !cmd_wr) |=> st_q == PH_IDLE);

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_IDLE && !cmd_wr) |=> st_q == PH_IDLE);

endmodule

// File: rtl/dual_bank_regport.sv
module dual_bank_regport
    import regport_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned IW     = 8,
    parameter int unsigned N16    = 4,
    parameter int unsigned N32    = 2,
    parameter int unsigned BASE32 = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    logic          rd_q, wr_q;
    logic          rd_fall, wr_fall;
    logic [DW-1:0] half [NUM_BANKS];

    // Previous strobe samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b1;
            wr_q <= 1'b1;
        end else begin
            rd_q <= rd_n;
            wr_q <= wr_n;
        end
    end

    assign rd_fall = rd_q & ~rd_n & ~cs_n;
    assign wr_fall = wr_q & ~wr_n & ~cs_n;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (addr[1] == b[0]);

        regport_bank #(
            .DW(DW), .IW(IW), .N16(N16), .N32(N32), .BASE32(BASE32)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd_wr (wr_fall & sel & addr[0]),
            .dat_wr (wr_fall & sel & ~addr[0]),
            .dat_rd (rd_fall & sel & ~addr[0]),
            .din    (din),
            .rd_half(half[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= '0;
        else if (rd_fall) dout <= addr[0] ? '0 : half[addr[1]];
    end

    assert_cs_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(dout));

    assert_dout_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |=> $stable(dout));

endmodule

// File: tb/tb_dual_bank_regport.sv
`timescale 1ns/1ps
module tb_dual_bank_regport;

    localparam logic [1:0] HD = 2'd0, HC = 2'd1, DD = 2'd2, DC = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;

    int compared = 0, mismatched = 0;
    bit done = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    event        rd_evt;

    always #2 clk = ~clk;

    dual_bank_regport dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout)
    );

    // Monitor: pops the expected value and compares it with dout.
    always @(rd_evt) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (dout !== e) begin
            mismatched++;
            $display("FAIL %s: dout=%h expected=%h", t, dout, e);
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d,
                          input bit cs = 1'b1, input int hold = 1);
        @(negedge clk);
        addr = a; din = d; cs_n = ~cs; wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [15:0] e,
                          input string t, input bit cs = 1'b1);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        addr = a; cs_n = ~cs; rd_n = 1'b0;
        @(negedge clk);
        -> rd_evt;
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic peek(input logic [15:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        -> rd_evt;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R8: reset contents, data phase without command.
        peek(16'h0000, "R1 dout after reset");
        bus_rd(HD, 16'h0000, "R8 read with no command");
        bus_wr(HD, 16'hDEAD);
        bus_wr(HC, 16'h0000);
        bus_rd(HD, 16'h0000, "R1 reg 0x00 reset / R8 write ignored");
        bus_wr(DC, 16'h0010);
        bus_rd(DD, 16'h0000, "R1 device 0x10 lo reset");
        bus_rd(DD, 16'h0000, "R1 device 0x10 hi reset");

        // R5: 16-bit write and read.
        bus_wr(HC, 16'h0002); bus_wr(HD, 16'h1234);
        bus_wr(HC, 16'h0002); bus_rd(HD, 16'h1234, "R5 16-bit readback");
        // R7: sequence closed.
        bus_rd(HD, 16'h0000, "R7 read after complete");
        bus_wr(HD, 16'hFFFF);
        bus_wr(HC, 16'h0002); bus_rd(HD, 16'h1234, "R7 write after complete ignored");

        // R6: deferred commit, half ordering.
        bus_wr(HC, 16'h0010); bus_wr(HD, 16'hBEEF);
        bus_wr(HC, 16'h0010);
        bus_rd(HD, 16'h0000, "R6 lo not committed");
        bus_rd(HD, 16'h0000, "R6 hi not committed");
        bus_wr(HC, 16'h0010); bus_wr(HD, 16'hBEEF); bus_wr(HD, 16'hCAFE);
        bus_wr(HC, 16'h0010);
        bus_rd(HD, 16'hBEEF, "R6 lo half");
        bus_rd(HD, 16'hCAFE, "R6 hi half");
        bus_rd(HD, 16'h0000, "R7 read after 32-bit complete");

        // R3: bank routing.
        bus_wr(DC, 16'h0010); bus_rd(DD, 16'h0000, "R3 device 0x10 untouched");
        bus_wr(DC, 16'h0002); bus_wr(DD, 16'h5A5A);
        bus_wr(HC, 16'h0002); bus_rd(HD, 16'h1234, "R3 host 0x02 untouched");
        bus_wr(DC, 16'h0002); bus_rd(DD, 16'h5A5A, "R3 device 0x02");

        // R10: interleaved 32-bit writes.
        bus_wr(HC, 16'h0011); bus_wr(HD, 16'h1111);
        bus_wr(DC, 16'h0011); bus_wr(DD, 16'h2222);
        bus_wr(HD, 16'h3333); bus_wr(DD, 16'h4444);
        bus_wr(HC, 16'h0011);
        bus_rd(HD, 16'h1111, "R10 host lo"); bus_rd(HD, 16'h3333, "R10 host hi");
        bus_wr(DC, 16'h0011);
        bus_rd(DD, 16'h2222, "R10 device lo"); bus_rd(DD, 16'h4444, "R10 device hi");

        // R11: restart mid-sequence.
        bus_wr(HC, 16'h0011); bus_wr(HD, 16'hAAAA);
        bus_wr(HC, 16'h0011); bus_wr(HD, 16'h0B0B); bus_wr(HD, 16'h0C0C);
        bus_wr(HC, 16'h0011);
        bus_rd(HD, 16'h0B0B, "R11 lo after restart");
        bus_rd(HD, 16'h0C0C, "R11 hi after restart");

        // R9: undefined index.
        bus_wr(HC, 16'h0007); bus_wr(HD, 16'h7777);
        bus_wr(HC, 16'h0007); bus_rd(HD, 16'h0000, "R9 undefined reads zero");
        bus_wr(HC, 16'h0003); bus_rd(HD, 16'h0000, "R9 neighbour untouched");

        // R4: command port read returns zero and keeps the sequence.
        bus_wr(HC, 16'h0002);
        bus_rd(HC, 16'h0000, "R4 command port read");
        bus_rd(HD, 16'h1234, "R4 sequence intact");

        // R2: chip select high.
        bus_wr(HC, 16'h0002);
        bus_wr(HD, 16'h9999, 1'b0);
        bus_rd(HD, 16'h1234, "R2 write without cs ignored");
        bus_wr(HC, 16'h0000);
        bus_rd(HD, 16'h1234, "R2 read without cs keeps dout", 1'b0);
        bus_rd(HD, 16'h0000, "R2 sequence not advanced");

        // R12: long strobe counts once.
        bus_wr(HC, 16'h0010); bus_wr(HD, 16'hAAAA, 1'b1, 4); bus_wr(HD, 16'hBBBB);
        bus_wr(HC, 16'h0010);
        bus_rd(HD, 16'hAAAA, "R12 lo once"); bus_rd(HD, 16'hBBBB, "R12 hi once");

        // R13: dout holds between reads.
        repeat (5) @(negedge clk);
        peek(16'hBBBB, "R13 dout held");

        #1;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++; mismatched++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule